// File: doc/BRIEF.md
# Opcode Prebyte Page Decoder

This block sits in an instruction-fetch path. It takes one opcode byte for each cycle in which its input strobe is high. Most byte values are complete opcodes on the base page. Three byte values are prebytes. A prebyte does not start an instruction; it selects an alternate opcode page for the single byte that follows it.

For each finished opcode the block emits a page field and the opcode byte, together with a one-cycle valid pulse. It also reports whether a prebyte came before the opcode. The page selection always drops back to the base page after one opcode. A flush input discards any pending prebyte, for example when a branch redirects fetch. The block does not decode instructions within a page, fetch operands or execute anything.

Top module: `pbd_page_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `op_vld` low and no prebyte pending; the first byte after reset is decoded on the base page.
- R2: A byte other than 0x18, 0x1A and 0xCD, accepted with no prebyte pending, is emitted one cycle later with `op_page` = 0 (base page), `op_byte` equal to the byte and `op_prefix` = 0.
- R3: An accepted 0x18 with no prebyte pending produces no output; the next accepted byte is emitted with `op_page` = 1.
- R4: An accepted 0x1A with no prebyte pending produces no output; the next accepted byte is emitted with `op_page` = 2.
- R5: An accepted 0xCD with no prebyte pending produces no output; the next accepted byte is emitted with `op_page` = 3.
- R6: A page selection covers only one opcode byte; the accepted byte after that is decoded on the base page again.
- R7: The byte accepted after a prebyte is always the opcode on the selected page, even when it equals a prebyte value, so prebytes never chain.
- R8: A cycle with `flush` high clears any pending prebyte and discards any byte offered in that cycle, so the next cycle shows `op_vld` low.
- R9: `op_prefix` is 1 on an emitted opcode that followed a prebyte and 0 otherwise.
- R10: Cycles with `byte_vld` low emit nothing and keep a pending prebyte unchanged.
- R11: `op_vld` is high for exactly one cycle per emitted opcode; it stays low in any cycle that follows a cycle with no emitting byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard pending prebyte and the current byte |
| byte_vld | input | 1 | `byte_in` holds a fetched byte this cycle |
| byte_in | input | 8 | Fetched byte |
| op_vld | output | 1 | One-cycle pulse: an opcode is on the outputs |
| op_page | output | 2 | Page minus one (0 = base page, 1..3 = alternate pages) |
| op_byte | output | 8 | Opcode byte within the page |
| op_prefix | output | 1 | Number of prebytes consumed for this opcode (0 or 1) |

## Verification
The hardest situations to reach are timing combinations around a pending prebyte. These are a prebyte followed by another prebyte value, a prebyte left waiting across idle cycles, and a flush that arrives in the very cycle the second byte is offered. Directed sequences build each of these cases on purpose. A long stretch of stimulus weighted toward the three prebyte values, with gaps in the strobe and occasional flushes, then produces many more such overlaps. Every cycle is compared against a behavioural model kept in the bench.

// File: rtl/pbd_pkg.sv
// Package: shared constants and types for the prebyte page decoder.
// Assumes at most three alternate pages, so a page index fits in two bits.
package pbd_pkg;
    localparam int unsigned PBD_BYTE_W  = 8;
    localparam int unsigned PBD_N_ALT   = 3;
    localparam int unsigned PBD_PAGE_W  = $clog2(PBD_N_ALT + 1);

    typedef logic [PBD_PAGE_W-1:0] pbd_page_t;

    // One decoded opcode, as handed to the output register.
    typedef struct packed {
        pbd_page_t                 page;
        logic [PBD_BYTE_W-1:0]     code;
        logic                      prefixed;
    } pbd_op_t;
endpackage

// File: rtl/pbd_prebyte_match.sv
// Module: pbd_prebyte_match
// Compares the incoming byte against each prebyte code and returns the
// alternate page it selects (code i selects page field i+1), or 0 when the
// byte is not a prebyte. Assumes the codes are distinct from one another.
module pbd_prebyte_match #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned N_ALT  = 3,
    parameter logic [N_ALT-1:0][BYTE_W-1:0] CODES = {8'hCD, 8'h1A, 8'h18},
    localparam int unsigned PAGE_W = $clog2(N_ALT + 1)
) (
    input  logic [BYTE_W-1:0] byte_in,
    output logic [PAGE_W-1:0] hit_page
);
    logic [N_ALT-1:0] hit_vec;

    // One comparator per prebyte code.
    for (genvar gi = 0; gi < N_ALT; gi++) begin : g_cmp
        assign hit_vec[gi] = (byte_in == CODES[gi]);
    end

    // Encode the matching comparator into a page field (lowest index wins).
    always_comb begin
        hit_page = '0;
        for (int i = N_ALT - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_page = PAGE_W'(i + 1);
        end
    end

    // Distinct codes mean at most one comparator fires (R3, R4, R5).
    always_comb begin
        AST_ONE_CODE_HIT: assert ($onehot0(hit_vec)); // R5
    end
endmodule

// File: rtl/pbd_page_track.sv
// Module: pbd_page_track
// Holds the page selected by a pending prebyte and decides, per accepted
// byte, whether an opcode is finished. Assumes byte_in is stable while
// byte_vld is high; flush takes priority over any accepted byte.
module pbd_page_track #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [PAGE_W-1:0] hit_page,
    output logic              emit_go,
    output logic [PAGE_W-1:0] emit_page,
    output logic [BYTE_W-1:0] emit_code,
    output logic              emit_prefixed
);
    logic [PAGE_W-1:0] pend_page_q;
    logic [PAGE_W-1:0] pend_page_d;
    logic              pend_q;
    logic              take;

    assign pend_q = (pend_page_q != '0);
    assign take   = byte_vld && !flush;

    // Next pending page: set by a prebyte, cleared by any follow-up or flush.
    always_comb begin
        pend_page_d = pend_page_q;
        if (flush) begin
            pend_page_d = '0;
        end else if (byte_vld) begin
            pend_page_d = pend_q ? '0 : hit_page;
        end
    end

    // Pending page register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_page_q <= '0;
        else        pend_page_q <= pend_page_d;
    end

    // An opcode is finished by any accepted byte except an unprefixed prebyte.
    always_comb begin
        emit_go       = take && (pend_q || (hit_page == '0));
        emit_page     = pend_q ? pend_page_q : '0;
        emit_code     = byte_in;
        emit_prefixed = pend_q;
    end

    AST_PEND_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && byte_vld) |=> !pend_q); // R6
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pend_q); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld && !flush) |=> $stable(pend_page_q)); // R10
endmodule

// File: rtl/pbd_emit_reg.sv
// Module: pbd_emit_reg
// Registers a finished opcode onto the block outputs as a one-cycle pulse.
// Assumes the payload is only meaningful while the valid flag is high.
module pbd_emit_reg #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [PAGE_W-1:0] page_in,
    input  logic [BYTE_W-1:0] code_in,
    input  logic              prefixed_in,
    output logic              vld,
    output logic [PAGE_W-1:0] page_out,
    output logic [BYTE_W-1:0] code_out,
    output logic              prefixed_out
);
    // Valid flag: follows go, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= 1'b0;
        else        vld <= go;
    end

    // Payload: loaded only when an opcode is finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_out     <= '0;
            code_out     <= '0;
            prefixed_out <= 1'b0;
        end else if (go) begin
            page_out     <= page_in;
            code_out     <= code_in;
            prefixed_out <= prefixed_in;
        end
    end

    AST_PAGE_MATCHES_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (prefixed_out == (page_out != '0))); // R9
endmodule

// File: rtl/pbd_page_decoder.sv
// Module: pbd_page_decoder (top)
// Turns a stream of fetched bytes into {page, opcode} pairs: a prebyte
// selects an alternate page for exactly the next byte. Assumes one byte per
// cycle at most and a synchronous active-low reset.
module pbd_page_decoder #(
    parameter int unsigned BYTE_W = pbd_pkg::PBD_BYTE_W,
    parameter int unsigned N_ALT  = pbd_pkg::PBD_N_ALT,
    parameter logic [N_ALT-1:0][BYTE_W-1:0] CODES = {8'hCD, 8'h1A, 8'h18},
    localparam int unsigned PAGE_W = $clog2(N_ALT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              op_vld,
    output logic [PAGE_W-1:0] op_page,
    output logic [BYTE_W-1:0] op_byte,
    output logic              op_prefix
);
    logic [PAGE_W-1:0] hit_page;
    logic              emit_go;
    logic [PAGE_W-1:0] emit_page;
    logic [BYTE_W-1:0] emit_code;
    logic              emit_prefixed;

    pbd_prebyte_match #(.BYTE_W(BYTE_W), .N_ALT(N_ALT), .CODES(CODES)) u_match (
        .byte_in  (byte_in),
        .hit_page (hit_page)
    );

    pbd_page_track #(.BYTE_W(BYTE_W), .PAGE_W(PAGE_W)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .byte_vld      (byte_vld),
        .byte_in       (byte_in),
        .hit_page      (hit_page),
        .emit_go       (emit_go),
        .emit_page     (emit_page),
        .emit_code     (emit_code),
        .emit_prefixed (emit_prefixed)
    );

    pbd_emit_reg #(.BYTE_W(BYTE_W), .PAGE_W(PAGE_W)) u_emit (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (emit_go),
        .page_in      (emit_page),
        .code_in      (emit_code),
        .prefixed_in  (emit_prefixed),
        .vld          (op_vld),
        .page_out     (op_page),
        .code_out     (op_byte),
        .prefixed_out (op_prefix)
    );

    AST_FLUSH_NO_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !op_vld); // R8
    AST_IDLE_NO_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> !op_vld); // R10
    AST_BASE_PAGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !flush && !op_prefix && !$past(op_vld) && hit_page == '0
         && emit_page == '0 && !emit_prefixed)
        |=> (op_vld && op_page == '0 && op_byte == $past(byte_in))); // R2
endmodule

// File: tb/pbd_page_decoder_tb.sv
// Bench: behavioural reference model compared against the design every cycle.
module pbd_page_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       op_vld;
    logic [1:0] op_page;
    logic [7:0] op_byte;
    logic       op_prefix;

    int n_chk = 0;
    int n_bad = 0;
    bit checking = 1'b0;

    // Reference model state.
    int    m_pend = 0;      // 0: none, else selected page field
    bit    e_vld = 1'b0;
    int    e_page = 0;
    int    e_byte = 0;
    int    e_pre = 0;
    string e_tag = "R1";
    bit    last_prefixed = 1'b0;

    always #5ns clk = ~clk;

    pbd_page_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .byte_vld(byte_vld),
        .byte_in(byte_in), .op_vld(op_vld), .op_page(op_page),
        .op_byte(op_byte), .op_prefix(op_prefix)
    );

    function automatic int page_of(input logic [7:0] b);
        if (b == 8'h18) return 1;
        if (b == 8'h1A) return 2;
        if (b == 8'hCD) return 3;
        return 0;
    endfunction

    // Model: computes what the outputs must show after this edge.
    always @(posedge clk) begin
        bit prev_vld;
        prev_vld = e_vld;
        if (!rst_n) begin
            m_pend = 0; e_vld = 0; e_tag = "R1"; last_prefixed = 0;
        end else if (flush) begin
            m_pend = 0; e_vld = 0; e_tag = "R8";
        end else if (!byte_vld) begin
            e_vld = 0; e_tag = prev_vld ? "R11" : "R10";
        end else if (m_pend != 0) begin
            e_vld = 1; e_page = m_pend; e_byte = int'(byte_in); e_pre = 1;
            if (page_of(byte_in) != 0) e_tag = "R7,R9";
            else if (m_pend == 1) e_tag = "R3,R9";
            else if (m_pend == 2) e_tag = "R4,R9";
            else e_tag = "R5,R9";
            m_pend = 0; last_prefixed = 1;
        end else if (page_of(byte_in) != 0) begin
            m_pend = page_of(byte_in); e_vld = 0; e_tag = "R3";
        end else begin
            e_vld = 1; e_page = 0; e_byte = int'(byte_in); e_pre = 0;
            e_tag = last_prefixed ? "R6" : "R2";
            last_prefixed = 0;
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            n_chk++;
            if (op_vld !== e_vld) begin
                n_bad++;
                $display("FAIL %s op_vld actual=%0b expected=%0b", e_tag, op_vld, e_vld);
            end else if (e_vld && (int'(op_page) != e_page || int'(op_byte) != e_byte
                                   || int'(op_prefix) != e_pre)) begin
                n_bad++;
                $display("FAIL %s actual={%0d,%02h,%0d} expected={%0d,%02h,%0d}",
                         e_tag, op_page, op_byte, op_prefix, e_page, e_byte, e_pre);
            end
        end
    end

    task automatic put(input logic [7:0] b);
        byte_vld = 1'b1; byte_in = b; flush = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b0; flush = 1'b0; byte_in = 8'hEE;
            @(negedge clk);
        end
    endtask

    task automatic put_flush(input bit v, input logic [7:0] b);
        byte_vld = v; byte_in = b; flush = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10ns);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset, including a prebyte offered during reset.
        @(negedge clk);
        byte_vld = 1'b1; byte_in = 8'h18;
        @(negedge clk);
        checking = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first byte after reset on base page (R2).
        put(8'h3C);
        put(8'hA5);
        // R3, R4, R5 with R9.
        put(8'h18); put(8'h3C);
        put(8'h1A); put(8'h01);
        put(8'hCD); put(8'hFF);
        // R6: revert after one byte.
        put(8'h18); put(8'h20); put(8'h20);
        // R7: prebyte value taken literally.
        put(8'h1A); put(8'h18); put(8'h18); put(8'h44);
        put(8'hCD); put(8'hCD); put(8'h00);
        // R10: pending held over idle cycles, R11 pulse.
        put(8'h18); idle(3); put(8'h77); idle(2);
        // R8: flush with pending, flush same cycle as follow-up byte.
        put(8'hCD); put_flush(1'b0, 8'h00); put(8'h55);
        put(8'h1A); put_flush(1'b1, 8'h66); put(8'h66);
        put_flush(1'b1, 8'h12); idle(1);
        // R1: reset mid-prefix clears pending.
        put(8'h18);
        rst_n = 1'b0; put(8'h99); rst_n = 1'b1;
        put(8'h42);
        // Weighted stream.
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [7:0] b;
            r = int'($urandom_range(0, 9));
            if (r < 2) b = 8'h18;
            else if (r < 3) b = 8'h1A;
            else if (r < 4) b = 8'hCD;
            else b = 8'($urandom);
            byte_vld = ($urandom_range(0, 9) < 7);
            flush = ($urandom_range(0, 31) == 0);
            byte_in = b;
            @(negedge clk);
        end
        idle(2);
        finish_run();
    end
endmodule